// File: doc/BRIEF.md
# I2C Control and Status Register Slave with Reset Flag

This block is the host-side register port of a receiver that produces data words. A host controller, acting as I2C master, writes two configuration bytes and reads back a status byte followed by the newest captured data word. The block is a slave only. SCL is always an input. SDA is open-drain: `sda_oe` high pulls the line low. All logic runs on one system clock. That clock must be at least about twenty times the SCL rate, which covers standard mode and fast mode up to 400 kbit/s.

The block merges three internal reset causes into one: power-up (`rst_n`), a supply drop (`supply_low`) and loss of oscillator activity. Oscillator loss is found by a watchdog on the slow `osc_act` toggle. Any of these causes sets a sticky reset-detected flag, which the host sees in the status byte. The internal reset also puts every register back to its default. The one exception is the oscillator-select bit `cfg1[0]`, which only power-up clears.

Each `data_stb` pulse captures `data_word` and drives the active-low `data_avail_n` output. A host can poll this output or use it as an interrupt. The output releases only when a read has fully delivered the word the host was given.

Top module: `rx_ctrl_regif`

## Requirements
- R1: An address byte whose upper seven bits equal `DEV_ADDR` is acknowledged. Bit 0 of the address byte selects the direction: 1 is read, 0 is write. Any other address is not acknowledged, and SDA stays released until the next start.
- R2: In a write, the first data byte loads `cfg0` and the second loads `cfg1`, and each is acknowledged. A third or later data byte is not acknowledged and changes nothing.
- R3: A read returns a status byte first: bit 7 is the reset-detected flag, bit 6 is data-available, and bits 5:0 are zero. The data bytes follow, most significant byte of the captured word first; reads past the word return 0x00. A master NACK ends the read and releases SDA.
- R4: Every internal reset sets the reset-detected flag. The flag clears only when the host has clocked the acknowledge slot of a status byte.
- R5: An internal reset from any cause aborts any transfer and releases SDA. It also clears data-available, sets `cfg0` to `CFG0_DEF` and sets `cfg1[7:1]` to `CFG1_DEF[7:1]`. `cfg1[0]` keeps its value through a supply-drop or watchdog reset; only `rst_n` clears it.
- R6: If `osc_act` shows no edge for `WD_CYCLES` clocks, the block stays in internal reset until activity resumes. During that time it acknowledges nothing.
- R7: `data_avail_n` goes low on the clock edge after the edge that samples `data_stb`, and `data_word` is captured at that point.
- R8: A read's data bytes come from the word held when its address was acknowledged. `data_avail_n` returns high only when the acknowledge slot of the last data byte is clocked, and stays low if a new strobe arrived after that read's address phase.
- R9: A start or stop condition at any bit position aborts the byte in progress without any register write. A repeated start begins a new address phase.
- R10: SCL and SDA each pass through a two-flop synchronizer and a filter. A level change shorter than `FILT_LEN` clocks is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Power-up reset, active low, asynchronous |
| supply_low | input | 1 | Supply-drop indication, asynchronous level |
| osc_act | input | 1 | Slow oscillator activity toggle |
| scl_i | input | 1 | I2C clock line |
| sda_i | input | 1 | I2C data line as seen on the bus |
| sda_oe | output | 1 | Pull SDA low when high |
| data_stb | input | 1 | New-data strobe, one clock |
| data_word | input | 8*DATA_BYTES | Data word captured on the strobe |
| data_avail_n | output | 1 | Data available, active low |
| cfg0 | output | 8 | Configuration register 0 |
| cfg1 | output | 8 | Configuration register 1, bit 0 is oscillator select |

## Verification
A corrupted bit counter or protocol state first shows up as an acknowledge in the wrong slot, or a missing one, within the same byte. The next data byte then comes back shifted or stuck. A wrong reset-detected flag or data-available register is visible one transaction later, in the status byte or on `data_avail_n`, and a wrong read pointer shows up in the data bytes of the same read. The configuration outputs reveal a mis-steered write or a missed reset default straight after the stop condition. A filter that passes glitches shows up as a wrong `cfg0` value or a lost acknowledge in the glitched byte.

// File: rtl/rx_ctrl_regif.sv
module rx_ctrl_regif #(
  parameter logic [6:0] DEV_ADDR   = 7'h34,
  parameter int         DATA_BYTES = 2,
  parameter int         FILT_LEN   = 4,
  parameter int         WD_CYCLES  = 4000,
  parameter logic [7:0] CFG0_DEF   = 8'h1C,
  parameter logic [7:0] CFG1_DEF   = 8'h62
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    supply_low,
  input  logic                    osc_act,
  input  logic                    scl_i,
  input  logic                    sda_i,
  output logic                    sda_oe,
  input  logic                    data_stb,
  input  logic [8*DATA_BYTES-1:0] data_word,
  output logic                    data_avail_n,
  output logic [7:0]              cfg0,
  output logic [7:0]              cfg1
);

  localparam int DW = 8*DATA_BYTES;
  localparam int PW = $clog2(DATA_BYTES+2);
  localparam int FW = $clog2(FILT_LEN+1);
  localparam int WW = $clog2(WD_CYCLES+1);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_ACKA, S_WR, S_ACKW, S_RD, S_ACKR} st_t;

  logic [1:0]    bo_s;
  logic [2:0]    osc_s;
  logic [WW-1:0] wd_cnt;
  logic          wd_dead, irst_q, core_rst_n;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      bo_s   <= '0;
      osc_s  <= '0;
      wd_cnt <= '0;
      irst_q <= 1'b0;
    end else begin
      bo_s  <= {bo_s[0], supply_low};
      osc_s <= {osc_s[1:0], osc_act};
      if (osc_s[2] != osc_s[1]) wd_cnt <= '0;
      else if (!wd_dead)        wd_cnt <= wd_cnt + 1'b1;
      irst_q <= bo_s[1] | wd_dead;
    end

  assign wd_dead    = (wd_cnt == WW'(WD_CYCLES));
  assign core_rst_n = rst_n & ~irst_q;

  st_t           st;
  logic [1:0]    sy0, sy1, filt, fprev;
  logic [FW-1:0] fcnt [2];
  logic [3:0]    bitcnt;
  logic [7:0]    sr, tx, nxt_b;
  logic          rw, acked, rst_det, avail, reading, late_stb, osc_sel;
  logic [1:0]    wptr;
  logic [PW-1:0] rptr;
  logic [DW-1:0] hold, obuf;
  logic [6:0]    cfg1_hi;
  logic          scl_r, scl_f, start_c, stop_c, wr1;

  assign scl_r   =  filt[0] & ~fprev[0];
  assign scl_f   = ~filt[0] &  fprev[0];
  assign start_c =  filt[0] &  fprev[0] &  fprev[1] & ~filt[1];
  assign stop_c  =  filt[0] &  fprev[0] & ~fprev[1] &  filt[1];
  assign wr1     = (st == S_WR) && scl_f && bitcnt == 4'd8 && wptr == 2'd1 && !start_c && !stop_c;

  always_comb begin
    nxt_b = 8'h00;
    for (int k = 1; k <= DATA_BYTES; k++)
      if (int'(rptr) == k) nxt_b = obuf[(DATA_BYTES-k)*8 +: 8];
  end

  always_ff @(posedge clk or negedge core_rst_n)
    if (!core_rst_n) begin
      st       <= S_IDLE;
      sy0      <= 2'b11;
      sy1      <= 2'b11;
      filt     <= 2'b11;
      fprev    <= 2'b11;
      fcnt[0]  <= '0;
      fcnt[1]  <= '0;
      bitcnt   <= '0;
      sr       <= '0;
      tx       <= '0;
      rw       <= 1'b0;
      acked    <= 1'b0;
      wptr     <= '0;
      rptr     <= '0;
      sda_oe   <= 1'b0;
      rst_det  <= 1'b1;
      avail    <= 1'b0;
      reading  <= 1'b0;
      late_stb <= 1'b0;
      hold     <= '0;
      obuf     <= '0;
      cfg0     <= CFG0_DEF;
      cfg1_hi  <= CFG1_DEF[7:1];
    end else begin
      sy0   <= {sda_i, scl_i};
      sy1   <= sy0;
      fprev <= filt;
      for (int i = 0; i < 2; i++)
        if (sy1[i] == filt[i]) fcnt[i] <= '0;
        else if (fcnt[i] == FW'(FILT_LEN-1)) begin
          filt[i] <= sy1[i];
          fcnt[i] <= '0;
        end else fcnt[i] <= fcnt[i] + 1'b1;

      if (data_stb) begin
        hold  <= data_word;
        avail <= 1'b1;
        if (reading) late_stb <= 1'b1;
      end

      if (start_c) begin
        st      <= S_ADDR;
        bitcnt  <= '0;
        sda_oe  <= 1'b0;
        reading <= 1'b0;
      end else if (stop_c) begin
        st      <= S_IDLE;
        sda_oe  <= 1'b0;
        reading <= 1'b0;
      end else begin
        case (st)
          S_ADDR:
            if (scl_r) begin
              sr     <= {sr[6:0], filt[1]};
              bitcnt <= bitcnt + 1'b1;
            end else if (scl_f && bitcnt == 4'd8) begin
              if (sr[7:1] == DEV_ADDR) begin
                sda_oe <= 1'b1;
                rw     <= sr[0];
                st     <= S_ACKA;
                if (sr[0]) begin
                  obuf     <= data_stb ? data_word : hold;
                  reading  <= 1'b1;
                  late_stb <= 1'b0;
                end
              end else st <= S_IDLE;
            end
          S_ACKA:
            if (scl_f) begin
              bitcnt <= '0;
              wptr   <= '0;
              rptr   <= '0;
              if (rw) begin
                tx     <= {rst_det, avail, 6'b0};
                sda_oe <= ~rst_det;
                st     <= S_RD;
              end else begin
                sda_oe <= 1'b0;
                st     <= S_WR;
              end
            end
          S_WR:
            if (scl_r) begin
              sr     <= {sr[6:0], filt[1]};
              bitcnt <= bitcnt + 1'b1;
            end else if (scl_f && bitcnt == 4'd8) begin
              if (wptr < 2'd2) begin
                if (wptr == 2'd0) cfg0 <= sr;
                else              cfg1_hi <= sr[7:1];
                wptr   <= wptr + 1'b1;
                sda_oe <= 1'b1;
                st     <= S_ACKW;
              end else st <= S_IDLE;
            end
          S_ACKW:
            if (scl_f) begin
              sda_oe <= 1'b0;
              bitcnt <= '0;
              st     <= S_WR;
            end
          S_RD:
            if (scl_r) bitcnt <= bitcnt + 1'b1;
            else if (scl_f) begin
              if (bitcnt == 4'd8) begin
                sda_oe <= 1'b0;
                st     <= S_ACKR;
              end else sda_oe <= ~tx[~bitcnt[2:0]];
            end
          S_ACKR:
            if (scl_r) begin
              acked <= ~filt[1];
              if (rptr == '0) rst_det <= 1'b0;
              if (int'(rptr) == DATA_BYTES && !late_stb && !data_stb) avail <= 1'b0;
              if (int'(rptr) <= DATA_BYTES) rptr <= rptr + 1'b1;
            end else if (scl_f) begin
              if (acked) begin
                tx     <= nxt_b;
                sda_oe <= ~nxt_b[7];
                bitcnt <= '0;
                st     <= S_RD;
              end else st <= S_IDLE;
            end
          default: st <= S_IDLE;
        endcase
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)   osc_sel <= 1'b0;
    else if (wr1) osc_sel <= sr[0];

  assign cfg1         = {cfg1_hi, osc_sel};
  assign data_avail_n = ~avail;

  assert_idle_release_R1: assert property (@(posedge clk) disable iff (!core_rst_n)
    (st == S_IDLE) |-> !sda_oe);
  assert_flag_clear_R4: assert property (@(posedge clk) disable iff (!core_rst_n)
    $fell(rst_det) |-> $past(st == S_ACKR && scl_r && rptr == '0));
  assert_osc_keep_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irst_q |=> $stable(cfg1[0]));
  assert_dead_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wd_dead |=> (data_avail_n && !sda_oe));
  assert_stb_avail_R7: assert property (@(posedge clk) disable iff (!core_rst_n)
    data_stb |=> !data_avail_n);
  assert_avail_hold_R8: assert property (@(posedge clk) disable iff (!core_rst_n)
    (!data_avail_n && !(st == S_ACKR && scl_r)) |=> !data_avail_n);
  assert_stop_idle_R9: assert property (@(posedge clk) disable iff (!core_rst_n)
    stop_c |=> (st == S_IDLE));

endmodule

// File: tb/test_rx_ctrl_regif.sv
module test_rx_ctrl_regif;
  localparam int Q = 40;
  localparam logic [6:0] DA = 7'h34;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0, supply_low = 1'b0, osc_act = 1'b0, osc_run = 1'b1;
  logic scl_m = 1'b1, sda_m = 1'b1, data_stb = 1'b0;
  logic [15:0] data_word = '0;
  logic sda_oe, data_avail_n;
  logic [7:0] cfg0, cfg1;
  wire sda_line = sda_m & ~sda_oe;

  rx_ctrl_regif #(.WD_CYCLES(300)) i_rx_ctrl_regif (
    .clk(clk), .rst_n(rst_n), .supply_low(supply_low), .osc_act(osc_act),
    .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .data_stb(data_stb), .data_word(data_word), .data_avail_n(data_avail_n),
    .cfg0(cfg0), .cfg1(cfg1));

  always begin
    repeat (25) @(negedge clk);
    if (osc_run) osc_act = ~osc_act;
  end

  int n_chk = 0, n_err = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic i2c_start();
    sda_m = 1'b1; w(Q); scl_m = 1'b1; w(Q); sda_m = 1'b0; w(Q); scl_m = 1'b0; w(Q);
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; w(Q); scl_m = 1'b1; w(Q); sda_m = 1'b1; w(Q);
  endtask

  task automatic send_bit(input logic v, input int sda_gl, input int scl_gl);
    sda_m = v;
    if (scl_gl != 0) begin
      w(Q/2); scl_m = 1'b1; w(2); scl_m = 1'b0; w(Q/2 - 2);
    end else w(Q);
    scl_m = 1'b1;
    if (sda_gl != 0) begin
      w(Q/2); sda_m = ~v; w(2); sda_m = v; w(3*Q/2 - 2);
    end else w(2*Q);
    scl_m = 1'b0; w(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) send_bit(b[i], 0, 0);
    sda_m = 1'b1; w(Q); scl_m = 1'b1; w(Q); ack = sda_line; w(Q); scl_m = 1'b0; w(Q);
  endtask

  task automatic recv_byte(input logic nack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1'b1; w(Q); scl_m = 1'b1; w(Q); b[i] = sda_line; w(Q); scl_m = 1'b0; w(Q);
    end
    sda_m = nack; w(Q); scl_m = 1'b1; w(2*Q); scl_m = 1'b0; w(Q); sda_m = 1'b1;
  endtask

  task automatic strobe(input logic [15:0] v);
    data_word = v; data_stb = 1'b1; w(1); data_stb = 1'b0;
  endtask

  task automatic read_status(input string tag, input logic [7:0] exp);
    logic a; logic [7:0] b;
    i2c_start(); send_byte({DA, 1'b1}, a);
    chk({tag, " read address ack"}, a, 0);
    recv_byte(1'b1, b); i2c_stop();
    chk({tag, " status byte"}, b, exp);
  endtask

  task automatic write_cfg0(input logic [7:0] v);
    logic a;
    i2c_start(); send_byte({DA, 1'b0}, a); send_byte(v, a); i2c_stop();
    chk("R2 cfg0 byte ack", a, 0);
  endtask

  task automatic t_reset();
    w(5); rst_n = 1'b1; w(5);
    chk("R5 cfg0 default", cfg0, 8'h1C);
    chk("R5 cfg1 default", cfg1, 8'h62);
    chk("R7 data_avail_n idle", data_avail_n, 1);
    chk("R5 sda released", sda_oe, 0);
  endtask

  task automatic t_wrong_addr();
    logic a;
    i2c_start(); send_byte({7'h35, 1'b0}, a);
    chk("R1 foreign address nack", a, 1);
    w(Q);
    chk("R1 sda released after nack", sda_oe, 0);
    i2c_stop();
  endtask

  task automatic t_write();
    logic a;
    i2c_start(); send_byte({DA, 1'b0}, a);
    chk("R1 write address ack", a, 0);
    send_byte(8'hA7, a); chk("R2 first byte ack", a, 0);
    send_byte(8'h3B, a); chk("R2 second byte ack", a, 0);
    send_byte(8'h99, a); chk("R2 third byte nack", a, 1);
    i2c_stop();
    chk("R2 cfg0 written", cfg0, 8'hA7);
    chk("R2 cfg1 written, extra byte ignored", cfg1, 8'h3B);
  endtask

  task automatic t_status();
    read_status("R4 power-up flag R3", 8'h80);
    read_status("R4 flag cleared by status read", 8'h00);
  endtask

  task automatic t_data();
    logic a; logic [7:0] b;
    strobe(16'hA55A); w(1);
    chk("R7 data_avail_n low after strobe", data_avail_n, 0);
    i2c_start(); send_byte({DA, 1'b1}, a);
    recv_byte(1'b0, b); chk("R3 status with data", b, 8'h40);
    recv_byte(1'b0, b); chk("R3 data high byte", b, 8'hA5);
    recv_byte(1'b1, b); chk("R3 data low byte", b, 8'h5A);
    w(Q);
    chk("R3 sda released after nack", sda_oe, 0);
    i2c_stop();
    chk("R8 data_avail_n released after last byte", data_avail_n, 1);
  endtask

  task automatic t_late_strobe();
    logic a; logic [7:0] b;
    strobe(16'h1234);
    i2c_start(); send_byte({DA, 1'b1}, a);
    recv_byte(1'b0, b); chk("R8 status before late strobe", b, 8'h40);
    strobe(16'hBEEF);
    recv_byte(1'b0, b); chk("R8 snapshot high byte", b, 8'h12);
    recv_byte(1'b1, b); chk("R8 snapshot low byte", b, 8'h34);
    i2c_stop();
    chk("R8 data_avail_n kept for late word", data_avail_n, 0);
    i2c_start(); send_byte({DA, 1'b1}, a);
    recv_byte(1'b0, b); recv_byte(1'b0, b); chk("R8 late word high byte", b, 8'hBE);
    recv_byte(1'b0, b); chk("R8 late word low byte", b, 8'hEF);
    recv_byte(1'b1, b); chk("R3 read past word returns zero", b, 8'h00);
    i2c_stop();
    chk("R8 data_avail_n released after late word", data_avail_n, 1);
  endtask

  task automatic t_abort();
    logic a; logic [7:0] b;
    i2c_start(); send_byte({DA, 1'b0}, a);
    for (int i = 0; i < 4; i++) send_bit(1'b1, 0, 0);
    i2c_stop();
    chk("R9 stop mid-byte leaves cfg0", cfg0, 8'hA7);
    i2c_start(); send_byte({DA, 1'b0}, a);
    for (int i = 0; i < 3; i++) send_bit(1'b0, 0, 0);
    i2c_start(); send_byte({DA, 1'b1}, a);
    chk("R9 repeated start address ack", a, 0);
    recv_byte(1'b1, b); i2c_stop();
    chk("R9 status after repeated start", b, 8'h00);
    chk("R9 cfg0 untouched by aborted byte", cfg0, 8'hA7);
  endtask

  task automatic t_glitch();
    logic a; logic [7:0] v = 8'h55;
    i2c_start(); send_byte({DA, 1'b0}, a);
    for (int i = 7; i >= 0; i--) send_bit(v[i], (i == 5) ? 1 : 0, (i == 2) ? 1 : 0);
    sda_m = 1'b1; w(Q); scl_m = 1'b1; w(Q); a = sda_line; w(Q); scl_m = 1'b0; w(Q);
    i2c_stop();
    chk("R10 glitched byte acked", a, 0);
    chk("R10 glitched byte value", cfg0, 8'h55);
  endtask

  task automatic t_brownout();
    strobe(16'h0F0F);
    supply_low = 1'b1; w(10); supply_low = 1'b0; w(10);
    chk("R5 cfg0 default after supply drop", cfg0, 8'h1C);
    chk("R5 cfg1 keeps oscillator bit", cfg1, 8'h63);
    chk("R5 data_avail_n cleared by reset", data_avail_n, 1);
    read_status("R4 supply-drop flag", 8'h80);
  endtask

  task automatic t_watchdog();
    logic a;
    write_cfg0(8'h77);
    chk("R2 cfg0 before oscillator loss", cfg0, 8'h77);
    osc_run = 1'b0; w(400);
    i2c_start(); send_byte({DA, 1'b1}, a);
    chk("R6 no ack while oscillator dead", a, 1);
    i2c_stop();
    chk("R6 cfg0 default after watchdog", cfg0, 8'h1C);
    osc_run = 1'b1; w(60);
    read_status("R6 watchdog flag R4", 8'h80);
    chk("R5 cfg1 oscillator bit after watchdog", cfg1, 8'h63);
  endtask

  initial begin
    t_reset();
    t_wrong_addr();
    t_write();
    t_status();
    t_data();
    t_late_strobe();
    t_abort();
    t_glitch();
    t_brownout();
    t_watchdog();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL timeout (all requirements): actual hung, expected completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule